// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar date in seven packed BCD registers: seconds, minutes, hours, day of week, date, month and year. A prescaler counts a 32.768 kHz clock enable and produces one advance per second. Each advance ripples through the fields in one clock cycle, applying the rules for 60-second minutes, 60-minute hours, the 12-hour or 24-hour format, the lengths of the months and leap years. The block drives every time register on its outputs, together with a one-cycle strobe marking each advance and the top bit of the prescaler.

Software loads any field through a simple write port made of an enable, a 3-bit field index and a data byte. Bit 7 of the seconds register halts the prescaler and all counting. A write to the seconds field restarts the sub-second prescaler, so the next advance comes one full second after that write. Bits that a field never uses are forced to zero when it is written. The serial host interface, the snapshot buffers seen by software and the power switching live outside this block.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the outputs read seconds 0x00, minutes 0x00, hours 0x00 (24-hour format, midnight), day of week 0x01, date 0x01, month 0x01, year 0x00, with sec_tick and half_tap low.
- R2: Seconds and minutes count in BCD from 00 to 59. The step after 59 gives 00 and carries into the next field.
- R3: With hours bit 6 = 0 (24-hour format) the hour counts in BCD from 00 to 23, with bit 5 acting as the tens-of-twenty bit. The step after 23:59:59 gives 00:00:00 and advances the day.
- R4: With hours bit 6 = 1 (12-hour format) bits 4:0 hold the hour 1 to 12 in BCD and bit 5 = 1 marks PM. Going from 11 to 12 toggles bit 5. Going from 12 to 01 leaves bit 5 alone. Only 11 PM to 12 AM advances the day.
- R5: On a day advance the date returns to 01 and the month advances after day 30 in April, June, September and November, after day 28 in February of a non-leap year, and after day 31 in every other month.
- R6: A year value divisible by four is a leap year, and there February runs to date 29.
- R7: Day of week (field 3) advances at each midnight and wraps from 7 to 1.
- R8: After December 31, 23:59:59 the month becomes 01 and the year advances in BCD, with 99 wrapping to 00.
- R9: While bit 7 of the seconds register is 1, the prescaler stops and no field changes unless it is written. Writing bit 7 back to 0 resumes counting.
- R10: A write to field 0 (seconds) clears the prescaler. With the enable present every cycle, the next sec_tick comes exactly 2^PRESCALE_W cycles after the write edge, and half_tap reads 0 right after the write.
- R11: A write stores only the used bits. Minutes and hours keep bits 6:0, day of week keeps bits 2:0, date keeps bits 5:0, month keeps bits 4:0, and seconds and year keep all 8 bits. The unused bits read 0.
- R12: sec_tick is high for exactly one cycle per advance, in the same cycle in which the advanced values first appear on the outputs. A cycle that carries a write takes priority and drops an advance that falls in it.
- R13: Field indices 0 to 6 select seconds, minutes, hours, day of week, date, month and year, in that order. A write to index 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | 32.768 kHz count enable, one cycle wide |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field index for the write |
| wr_data | input | 8 | Data to write, in BCD |
| sec_o | output | 8 | Halt bit and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Format bit, PM or tens-of-twenty bit, BCD hours |
| dow_o | output | 8 | Day of week, 1 to 7 |
| date_o | output | 8 | BCD date of the month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |
| sec_tick | output | 1 | One-cycle strobe for each advance |
| half_tap | output | 1 | Top bit of the sub-second prescaler |

## Verification
The bench builds the block with PRESCALE_W = 2, so one second lasts four enables instead of 32768. This makes each rollover cheap to reach: the bench loads the fields just short of a minute, day, month or year boundary and observes the carries within a few cycles. With a narrow prescaler the exact distance from a seconds write to the next strobe can also be counted cycle by cycle. The same short window lets the bench confirm that a halted clock produces no strobe over several would-be seconds.

// File: rtl/tk_pkg.sv
package tk_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int FIELD_W    = 8;

  localparam logic [2:0] F_SEC  = 3'd0;
  localparam logic [2:0] F_MIN  = 3'd1;
  localparam logic [2:0] F_HOUR = 3'd2;
  localparam logic [2:0] F_DOW  = 3'd3;
  localparam logic [2:0] F_DATE = 3'd4;
  localparam logic [2:0] F_MON  = 3'd5;
  localparam logic [2:0] F_YEAR = 3'd6;

  // Bits a field keeps on a write; the others stay zero.
  function automatic logic [FIELD_W-1:0] field_mask(input int idx);
    case (idx)
      1, 2:    return 8'h7F;
      3:       return 8'h07;
      4:       return 8'h3F;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] field_reset(input int idx);
    case (idx)
      3, 4, 5: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  // One BCD step of a two-digit value (no wrap handling).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // tens*10 + ones is divisible by 4 when 2*tens + ones is.
  function automatic logic bcd_div4(input logic [7:0] y);
    logic [1:0] r;
    r = {y[4], 1'b0} + y[1:0];
    return (r == 2'd0);
  endfunction

  function automatic logic [7:0] bcd_month_end(input logic [7:0] month,
                                               input logic [7:0] year);
    case (month)
      8'h02:                      return bcd_div4(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
  parameter int WIDTH = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic run,
  input  logic clear,
  output logic wrap,
  output logic tap
);
  logic [WIDTH-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clear)         cnt <= '0;
    else if (osc_en && run) cnt <= cnt + 1'b1;
  end

  assign wrap = osc_en && run && !clear && (&cnt);
  assign tap  = cnt[WIDTH-1];
endmodule

// File: rtl/tk_clock_step.sv
module tk_clock_step
  import tk_pkg::*;
(
  input  logic [7:0] sec,
  input  logic [7:0] min,
  input  logic [7:0] hour,
  output logic [7:0] sec_n,
  output logic [7:0] min_n,
  output logic [7:0] hour_n,
  output logic       day_carry
);
  logic       sec_wrap, min_wrap;
  logic [7:0] s_inc, m_inc, h12_inc, h24_inc;

  always_comb begin
    s_inc    = bcd_inc({1'b0, sec[6:0]});
    m_inc    = bcd_inc(min);
    h12_inc  = bcd_inc({3'b000, hour[4:0]});
    h24_inc  = bcd_inc({2'b00, hour[5:0]});
    sec_wrap = (sec[6:0] == 7'h59);
    min_wrap = (min == 8'h59);

    sec_n     = sec_wrap ? {sec[7], 7'h00} : {sec[7], s_inc[6:0]};
    min_n     = min;
    hour_n    = hour;
    day_carry = 1'b0;

    if (sec_wrap) begin
      min_n = min_wrap ? 8'h00 : m_inc;
      if (min_wrap) begin
        if (hour[6]) begin
          if (hour[4:0] == 5'h11) begin
            hour_n    = {hour[7:6], ~hour[5], 5'h12};
            day_carry = hour[5];
          end else if (hour[4:0] == 5'h12) begin
            hour_n = {hour[7:5], 5'h01};
          end else begin
            hour_n = {hour[7:5], h12_inc[4:0]};
          end
        end else begin
          if (hour[5:0] == 6'h23) begin
            hour_n    = {hour[7:6], 6'h00};
            day_carry = 1'b1;
          end else begin
            hour_n = {hour[7:6], h24_inc[5:0]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/tk_cal_step.sv
module tk_cal_step
  import tk_pkg::*;
(
  input  logic       day_carry,
  input  logic [7:0] dow,
  input  logic [7:0] date,
  input  logic [7:0] month,
  input  logic [7:0] year,
  output logic [7:0] dow_n,
  output logic [7:0] date_n,
  output logic [7:0] month_n,
  output logic [7:0] year_n
);
  logic       last_day, last_month;
  logic [7:0] d_inc, mo_inc, y_inc;

  always_comb begin
    d_inc      = bcd_inc(date);
    mo_inc     = bcd_inc(month);
    y_inc      = bcd_inc(year);
    last_day   = (date == bcd_month_end(month, year));
    last_month = (month == 8'h12);

    dow_n   = dow;
    date_n  = date;
    month_n = month;
    year_n  = year;

    if (day_carry) begin
      dow_n  = (dow[2:0] == 3'd7) ? 8'h01 : {5'b0, dow[2:0] + 3'd1};
      date_n = last_day ? 8'h01 : d_inc;
      if (last_day) begin
        month_n = last_month ? 8'h01 : mo_inc;
        if (last_month) year_n = (year == 8'h99) ? 8'h00 : y_inc;
      end
    end
  end
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import tk_pkg::*;
#(
  parameter int PRESCALE_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       sec_tick,
  output logic       half_tap
);
  logic [FIELD_W-1:0] fld [NUM_FIELDS];
  logic [FIELD_W-1:0] nxt [NUM_FIELDS];

  logic halted;
  logic sec_write;
  logic pre_wrap;
  logic advance;
  logic day_carry;

  assign halted    = fld[F_SEC][7];
  assign sec_write = wr_en && (wr_addr == F_SEC);
  assign advance   = pre_wrap && !wr_en;

  tk_prescaler #(.WIDTH(PRESCALE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_en (osc_en),
    .run    (!halted),
    .clear  (sec_write),
    .wrap   (pre_wrap),
    .tap    (half_tap)
  );

  tk_clock_step u_clk (
    .sec       (fld[F_SEC]),
    .min       (fld[F_MIN]),
    .hour      (fld[F_HOUR]),
    .sec_n     (nxt[F_SEC]),
    .min_n     (nxt[F_MIN]),
    .hour_n    (nxt[F_HOUR]),
    .day_carry (day_carry)
  );

  tk_cal_step u_cal (
    .day_carry (day_carry),
    .dow       (fld[F_DOW]),
    .date      (fld[F_DATE]),
    .month     (fld[F_MON]),
    .year      (fld[F_YEAR]),
    .dow_n     (nxt[F_DOW]),
    .date_n    (nxt[F_DATE]),
    .month_n   (nxt[F_MON]),
    .year_n    (nxt[F_YEAR])
  );

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam logic [FIELD_W-1:0] MASK = field_mask(i);
    localparam logic [FIELD_W-1:0] RSTV = field_reset(i);
    logic hit;
    assign hit = wr_en && (wr_addr == 3'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fld[i] <= RSTV;
      else if (hit)     fld[i] <= wr_data & MASK;
      else if (advance) fld[i] <= nxt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_tick <= 1'b0;
    else        sec_tick <= advance;
  end

  assign sec_o   = fld[F_SEC];
  assign min_o   = fld[F_MIN];
  assign hour_o  = fld[F_HOUR];
  assign dow_o   = fld[F_DOW];
  assign date_o  = fld[F_DATE];
  assign month_o = fld[F_MON];
  assign year_o  = fld[F_YEAR];
endmodule

// File: rtl/tk_checker.sv
module tk_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic       sec_tick,
  input logic       half_tap
);
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7] && !wr_en) |=> ($stable({sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o}) && !sec_tick)); // R9

  AST_SEC_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> (!sec_tick && !half_tap)); // R10

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick); // R12

  AST_FIXED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (min_o[7] == 1'b0) && (hour_o[7] == 1'b0) && (dow_o[7:3] == 5'd0) &&
    (date_o[7:6] == 2'd0) && (month_o[7:5] == 3'd0)); // R11

  AST_DOW_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dow_o[2:0] != 3'd0); // R7

  AST_SEC_BCD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[3:0] <= 4'd9) && (sec_o[6:4] <= 3'd5)); // R2
endmodule

bind bcd_timekeeper tk_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .sec_o    (sec_o),
  .min_o    (min_o),
  .hour_o   (hour_o),
  .dow_o    (dow_o),
  .date_o   (date_o),
  .month_o  (month_o),
  .year_o   (year_o),
  .sec_tick (sec_tick),
  .half_tap (half_tap)
);

// File: tb/sim_bcd_timekeeper.sv
module sim_bcd_timekeeper;
  localparam int PW = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic       sec_tick, half_tap;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  typedef logic [55:0] snap_t;
  snap_t exp_q[$];
  string tag_q[$];

  // bench-side calendar state in binary
  int m_sec, m_min, m_h24, m_dow, m_date, m_mon, m_yr;
  bit m_12h;

  always #4 clk = ~clk;

  bcd_timekeeper #(.PRESCALE_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o), .month_o(month_o),
    .year_o(year_o), .sec_tick(sec_tick), .half_tap(half_tap)
  );

  function automatic snap_t outs();
    return {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
  endfunction

  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] to_bcd(int v);
    int t;
    t = (v / 10) * 16 + (v % 10);
    return t[7:0];
  endfunction

  function automatic int days_in(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic snap_t model_snap();
    logic [7:0] h;
    int h12;
    if (m_12h) begin
      h12 = m_h24 % 12;
      if (h12 == 0) h12 = 12;
      h = 8'h40 | (m_h24 >= 12 ? 8'h20 : 8'h00) | to_bcd(h12);
    end else begin
      h = to_bcd(m_h24);
    end
    return {to_bcd(m_sec), to_bcd(m_min), h, to_bcd(m_dow), to_bcd(m_date),
            to_bcd(m_mon), to_bcd(m_yr)};
  endfunction

  task automatic model_step();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_h24++;
        if (m_h24 == 24) begin
          m_h24 = 0;
          m_dow = (m_dow == 7) ? 1 : m_dow + 1;
          m_date++;
          if (m_date > days_in(m_mon, m_yr)) begin
            m_date = 1; m_mon++;
            if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                          logic [7:0] dw, logic [7:0] dt, logic [7:0] mo,
                          logic [7:0] yr);
    int h12;
    osc_en = 1'b0;
    wr(3'd1, mi); wr(3'd2, h); wr(3'd3, dw); wr(3'd4, dt);
    wr(3'd5, mo); wr(3'd6, yr); wr(3'd0, s);
    m_sec = from_bcd({1'b0, s[6:0]}); m_min = from_bcd(mi);
    m_12h = h[6];
    if (h[6]) begin
      h12 = from_bcd({3'b0, h[4:0]});
      m_h24 = (h12 % 12) + (h[5] ? 12 : 0);
    end else begin
      m_h24 = from_bcd({2'b0, h[5:0]});
    end
    m_dow = from_bcd(dw); m_date = from_bcd(dt);
    m_mon = from_bcd(mo); m_yr = from_bcd(yr);
  endtask

  // driver: push expected snapshots, then let the clock run
  task automatic run_ticks(int n, string tag);
    int guard = 0;
    for (int i = 0; i < n; i++) begin
      model_step();
      exp_q.push_back(model_snap());
      tag_q.push_back(tag);
    end
    @(negedge clk);
    osc_en = 1'b1;
    while (exp_q.size() != 0 && guard < 1000) begin
      @(posedge clk); #1;
      guard++;
    end
    osc_en = 1'b0;
    if (guard >= 1000) check({tag, " tick timeout"}, 64'(exp_q.size()), 64'd0);
  endtask

  // monitor: compare on every strobe
  always @(negedge clk) begin
    if (rst_n && sec_tick) begin
      if (exp_q.size() == 0) begin
        nvec++; nbad++;
        $display("FAIL R12 unexpected tick actual %h expected none", outs());
      end else begin
        string t;
        snap_t e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 64'(outs()), 64'(e));
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset fields", 64'(outs()), 64'h00_00_00_01_01_01_00);
    check("R1 reset strobes", {62'd0, sec_tick, half_tap}, 64'd0);

    // R2 R3 R5 R7: Feb 28 of non-leap year 23, day 7, 24-hour
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    run_ticks(3, "R2/R3/R5/R7 midnight rollover");

    // R6 leap year: Feb 28 -> Feb 29 -> Mar 1
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    run_ticks(1, "R6 leap Feb 29");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
    run_ticks(1, "R6 leap end of Feb");

    // R5 30-day month
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h04, 8'h31);
    run_ticks(1, "R5 April 30");
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h05, 8'h31);
    run_ticks(1, "R5 May 30 no wrap");

    // R8 year end and 99 -> 00
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    run_ticks(2, "R8 year wrap");
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h09);
    run_ticks(1, "R8 year BCD carry");

    // R4 12-hour format
    set_time(8'h59, 8'h59, 8'h51, 8'h02, 8'h10, 8'h05, 8'h25);
    run_ticks(1, "R4 11AM to 12PM");
    set_time(8'h59, 8'h59, 8'h72, 8'h02, 8'h10, 8'h05, 8'h25);
    run_ticks(2, "R4 12PM to 1PM");
    set_time(8'h59, 8'h59, 8'h71, 8'h03, 8'h10, 8'h05, 8'h25);
    run_ticks(1, "R4 11PM to 12AM day advance");
    set_time(8'h59, 8'h59, 8'h52, 8'h03, 8'h11, 8'h05, 8'h25);
    run_ticks(1, "R4 12AM to 1AM");

    // R9 halt: several would-be seconds produce no strobe and no change
    set_time(8'h90, 8'h15, 8'h08, 8'h01, 8'h05, 8'h06, 8'h30);
    @(negedge clk);
    osc_en = 1'b1;
    repeat (20) @(negedge clk);
    osc_en = 1'b0;
    check("R9 halted fields", 64'(outs()), 64'h90_15_08_01_05_06_30);
    set_time(8'h10, 8'h15, 8'h08, 8'h01, 8'h05, 8'h06, 8'h30);
    run_ticks(2, "R9 resume after halt");

    // R13 write to index 7 has no effect
    wr(3'd7, 8'hFF);
    @(negedge clk);
    check("R13 index 7 ignored", 64'(outs()), 64'(model_snap()));

    // R11 unused bits dropped on write
    osc_en = 1'b0;
    wr(3'd1, 8'hC5); wr(3'd2, 8'h92); wr(3'd3, 8'hFB);
    wr(3'd4, 8'hD5); wr(3'd5, 8'hE7);
    @(negedge clk);
    check("R11 masked fields", 64'({min_o, hour_o, dow_o, date_o, month_o}),
          64'h45_12_03_15_07);

    // R10 seconds write restarts the prescaler; R12 single-cycle strobe
    set_time(8'h30, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    model_step();
    exp_q.push_back(model_snap());
    tag_q.push_back("R10 tick after seconds write");
    @(negedge clk);
    osc_en = 1'b1;
    repeat (3) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h30;
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 half_tap after write", {63'd0, half_tap}, 64'd0);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sec_tick && n < 20);
    check("R10 cycles to tick", 64'(n), 64'(1 << PW));
    @(negedge clk);
    check("R12 strobe one cycle", {63'd0, sec_tick}, 64'd0);
    osc_en = 1'b0;
    check("R10 queue drained", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule